// File: doc/BRIEF.md
# Instruction Snoop Inclusion Filter

This block sits next to an X-way instruction cache that replaces lines with a tree pseudo-LRU policy. When a store snoop arrives, it tells the pipeline whether that snoop may skip the slow, pessimistic check for modified instructions in flight. The decision rests on one property of pseudo-LRU: a line that was just used cannot be pushed out until log2(X) other ways of its set have been touched. The block never stores way identities. It keeps a snapshot of each set's LRU bits, and any change in that snapshot counts as "a different way was touched", which arms the set. Each set counts the evictions it has seen after such a change.

When a set reaches log2(X) counted evictions, or when an eviction arrives while no LRU change has been seen, the guarantee no longer holds. The whole filter then returns to its cleared state. Filtering stays off until every instruction that was in flight at that moment has retired. The block learns this from the pipeline's in-flight count, which it captures at the clear and then decrements on each retire pulse. The guarantee covers the whole pipeline, so the decision does not depend on which line is being snooped. A single output carries the verdict for the current snoop.

Top module: `ifl_inclusion_filter`

## Requirements
- R1: After reset, with no events, a snoop is filtered (`snoop_filter`=1).
- R2: `snoop_filter` is 0 in every cycle in which `snoop_valid` is 0.
- R3: An access whose LRU bits differ from the set's snapshot arms that set, and an access with equal bits does not arm it. Either way, the snapshot takes the access's value.
- R4: An eviction in an armed set adds one to that set's counter and disarms it. The eviction that would bring the counter to log2(`NUM_WAYS`) is a saturation.
- R5: An eviction in a set that is not armed is a saturation.
- R6: In a cycle that presents a saturating eviction, `snoop_filter` is 0.
- R7: A saturation clears the counter, the arm flag and the LRU snapshot (to all zeros) of every set.
- R8: At a saturation the drain count loads `inflight_cnt`. Each `retire` pulse lowers a nonzero count by one, and `retire` at zero does nothing. `snoop_filter` is 0 while the count is nonzero and follows `snoop_valid` again from the cycle after the count reaches zero.
- R9: A saturation while draining reloads the count from `inflight_cnt`, and a `retire` in that same cycle is ignored.
- R10: When an access and an eviction hit the same set in one cycle, the eviction uses the arm state from before that cycle, and the access may then re-arm the set.
- R11: Each set is armed and counted independently of the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Cache access reported this cycle |
| acc_set | input | $clog2(NUM_SETS) | Set of the access |
| acc_lru | input | NUM_WAYS-1 | LRU bits of that set after the access |
| evict_valid | input | 1 | Cache eviction reported this cycle |
| evict_set | input | $clog2(NUM_SETS) | Set of the eviction |
| retire | input | 1 | One instruction retired this cycle |
| inflight_cnt | input | INFL_W | Instructions currently in the pipeline |
| snoop_valid | input | 1 | A snoop needs a verdict this cycle |
| snoop_filter | output | 1 | 1: snoop may skip the inclusion check |

## Verification
The assertions assume that `inflight_cnt` never exceeds what `INFL_W` can hold. They also assume that `retire` pulses and cache events are single-cycle strobes sampled at the rising edge. The stimulus changes every input on the falling edge and keeps the in-flight values small. It reads the combinational verdict one time unit after each change. This way each saturation, reload and retire lands on a known edge, and the expected verdict can be computed by hand for every cycle.

// File: rtl/ifl_pkg.sv
// Package: shared sizing helpers for the inclusion filter.
// Assumes the way count is a power of two of at least 2.
package ifl_pkg;

    // Counted evictions a set tolerates before the pLRU guarantee lapses
    function automatic int sat_limit(input int ways);
        return $clog2(ways);
    endfunction

    // Counter width able to hold values 0 .. sat_limit
    function automatic int cnt_width(input int ways);
        return $clog2($clog2(ways) + 1);
    endfunction

endpackage

// File: rtl/ifl_set_tracker.sv
// Per-set tracker: holds an LRU snapshot, an arm flag and an eviction
// counter. It flags a saturation when an eviction arrives unarmed or
// would reach LIMIT. Assumes `clear` is asserted whenever any tracker
// (this one included) saturates, so a saturating state is never stored.
module ifl_set_tracker #(
    parameter int LRU_W = 7,
    parameter int CNT_W = 2,
    parameter int LIMIT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             acc_hit,
    input  logic [LRU_W-1:0] acc_lru,
    input  logic             ev_hit,
    output logic             sat,
    output logic [CNT_W-1:0] cnt
);

    logic [LRU_W-1:0] snap_q;
    logic             armed_q;
    logic [CNT_W-1:0] cnt_q;
    logic             lru_moved;

    // Purpose: an access that changes the pLRU bits means another way was touched
    assign lru_moved = acc_hit && (acc_lru != snap_q);

    // Purpose: eviction without a prior change, or at the limit, breaks the guarantee
    assign sat = ev_hit && (!armed_q || (cnt_q == CNT_W'(LIMIT - 1)));

    assign cnt = cnt_q;

    // Purpose: update snapshot, arm flag and counter; clear wins over all events
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            snap_q  <= '0;
            armed_q <= 1'b0;
            cnt_q   <= '0;
        end else begin
            if (ev_hit) begin
                cnt_q   <= cnt_q + 1'b1;
                armed_q <= 1'b0;
            end
            if (acc_hit) begin
                snap_q <= acc_lru;
            end
            if (lru_moved) begin
                armed_q <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/ifl_drain_timer.sv
// Drain timer: loads the in-flight count at a global clear and counts it
// down on retire pulses. It reports busy until the count is zero.
// Assumes a retire in the loading cycle is already part of load_val.
module ifl_drain_timer #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         retire,
    output logic         busy,
    output logic [W-1:0] count
);

    logic [W-1:0] cnt_q;

    // Purpose: load on clear, otherwise decrement on retire without underflow
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (retire && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy  = (cnt_q != '0);
    assign count = cnt_q;

endmodule

// File: rtl/ifl_inclusion_filter.sv
// Top: instruction snoop inclusion filter. It combines one tracker per
// set with a global drain timer into a single filter verdict.
// Assumes at most one access and one eviction are reported per cycle and
// that acc_lru is the set's tree pLRU state after the access.
module ifl_inclusion_filter #(
    parameter int NUM_WAYS = 8,
    parameter int NUM_SETS = 16,
    parameter int INFL_W   = 6
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        acc_valid,
    input  logic [$clog2(NUM_SETS)-1:0] acc_set,
    input  logic [NUM_WAYS-2:0]         acc_lru,
    input  logic                        evict_valid,
    input  logic [$clog2(NUM_SETS)-1:0] evict_set,
    input  logic                        retire,
    input  logic [INFL_W-1:0]           inflight_cnt,
    input  logic                        snoop_valid,
    output logic                        snoop_filter
);

    localparam int SET_W = $clog2(NUM_SETS);
    localparam int LRU_W = NUM_WAYS - 1;
    localparam int LIMIT = ifl_pkg::sat_limit(NUM_WAYS);
    localparam int CNT_W = ifl_pkg::cnt_width(NUM_WAYS);

    logic [NUM_SETS-1:0]       sat_vec;
    logic [NUM_SETS*CNT_W-1:0] cnt_flat;
    logic                      sat_any;
    logic                      busy;
    logic [INFL_W-1:0]         drain_cnt;

    // Purpose: one tracker per set, each decoding its own access/eviction strobe
    for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
        logic acc_hit;
        logic ev_hit;
        assign acc_hit = acc_valid   && (acc_set   == SET_W'(s));
        assign ev_hit  = evict_valid && (evict_set == SET_W'(s));

        ifl_set_tracker #(
            .LRU_W (LRU_W),
            .CNT_W (CNT_W),
            .LIMIT (LIMIT)
        ) i_trk (
            .clk     (clk),
            .rst_n   (rst_n),
            .clear   (sat_any),
            .acc_hit (acc_hit),
            .acc_lru (acc_lru),
            .ev_hit  (ev_hit),
            .sat     (sat_vec[s]),
            .cnt     (cnt_flat[s*CNT_W +: CNT_W])
        );
    end

    // Purpose: any saturating set triggers the global clear
    assign sat_any = |sat_vec;

    ifl_drain_timer #(
        .W (INFL_W)
    ) i_drain (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sat_any),
        .load_val (inflight_cnt),
        .retire   (retire),
        .busy     (busy),
        .count    (drain_cnt)
    );

    // Purpose: filter only when idle of drain and not in a saturating cycle
    assign snoop_filter = snoop_valid && !busy && !sat_any;

endmodule

// File: rtl/ifl_inclusion_filter_chk.sv
// Checker for the inclusion filter, bound to the top module below.
// Assumes a synchronous active-low reset and single-cycle event strobes.
module ifl_inclusion_filter_chk #(
    parameter int NUM_SETS = 16,
    parameter int CNT_W    = 2,
    parameter int INFL_W   = 6
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      snoop_valid,
    input logic                      snoop_filter,
    input logic                      sat_any,
    input logic                      retire,
    input logic [INFL_W-1:0]         inflight_cnt,
    input logic [INFL_W-1:0]         drain_cnt,
    input logic [NUM_SETS*CNT_W-1:0] cnt_flat
);

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !snoop_valid |-> !snoop_filter);

    p_sat_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sat_any |-> !snoop_filter);

    p_clear_counts_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sat_any |=> (cnt_flat == '0));

    p_drain_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (drain_cnt != '0) |-> !snoop_filter);

    p_drain_dec_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!sat_any && retire && (drain_cnt != '0)) |=>
            (drain_cnt == $past(drain_cnt) - 1'b1));

    p_drain_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!sat_any && !retire) |=> $stable(drain_cnt));

    p_reload_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sat_any |=> (drain_cnt == $past(inflight_cnt)));

endmodule

bind ifl_inclusion_filter ifl_inclusion_filter_chk #(
    .NUM_SETS (NUM_SETS),
    .CNT_W    (CNT_W),
    .INFL_W   (INFL_W)
) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .snoop_valid  (snoop_valid),
    .snoop_filter (snoop_filter),
    .sat_any      (sat_any),
    .retire       (retire),
    .inflight_cnt (inflight_cnt),
    .drain_cnt    (drain_cnt),
    .cnt_flat     (cnt_flat)
);

// File: tb/test_ifl_inclusion_filter.sv
// Bench: vector table walked once, then directed reset checks.
module test_ifl_inclusion_filter;

    localparam int CLK_PERIOD = 10;
    localparam int NROWS      = 55;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_valid = 1'b0;
    logic [3:0] acc_set = '0;
    logic [6:0] acc_lru = '0;
    logic       evict_valid = 1'b0;
    logic [3:0] evict_set = '0;
    logic       retire = 1'b0;
    logic [5:0] inflight_cnt = '0;
    logic       snoop_valid = 1'b0;
    logic       snoop_filter;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ifl_inclusion_filter i_ifl_inclusion_filter (
        .clk          (clk),
        .rst_n        (rst_n),
        .acc_valid    (acc_valid),
        .acc_set      (acc_set),
        .acc_lru      (acc_lru),
        .evict_valid  (evict_valid),
        .evict_set    (evict_set),
        .retire       (retire),
        .inflight_cnt (inflight_cnt),
        .snoop_valid  (snoop_valid),
        .snoop_filter (snoop_filter)
    );

    // Row: {req, acc_v, acc_set, acc_lru, ev_v, ev_set, retire, inflight, snoop, expected}
    function automatic logic [29:0] mk(input int rq, input int a, input int as_, input int al,
                                       input int e, input int es, input int r, input int inf,
                                       input int s, input int x);
        return {rq[3:0], a[0], as_[3:0], al[6:0], e[0], es[3:0], r[0], inf[5:0], s[0], x[0]};
    endfunction

    localparam logic [29:0] TBL [NROWS] = '{
        mk(1, 0,0,0,  0,0,  0,0, 1,1),   // 0  R1 idle after reset
        mk(2, 0,0,0,  0,0,  0,0, 0,0),   // 1  R2 no snoop
        mk(3, 1,1,5,  0,0,  0,0, 1,1),   // 2  R3 arm set1
        mk(4, 0,0,0,  1,1,  0,0, 1,1),   // 3  R4 count 1
        mk(3, 1,1,5,  0,0,  0,0, 1,1),   // 4  R3 equal bits
        mk(3, 1,1,6,  0,0,  0,0, 1,1),   // 5  R3 re-arm
        mk(4, 0,0,0,  1,1,  0,0, 1,1),   // 6  R4 count 2
        mk(3, 1,1,3,  0,0,  0,0, 1,1),   // 7  R3 arm
        mk(6, 0,0,0,  1,1,  0,4, 1,0),   // 8  R6 third eviction saturates
        mk(8, 0,0,0,  0,0,  1,0, 1,0),   // 9  R8 drain 4->3
        mk(8, 0,0,0,  0,0,  1,0, 1,0),   // 10 R8 3->2
        mk(8, 0,0,0,  0,0,  0,0, 1,0),   // 11 R8 hold 2
        mk(8, 0,0,0,  0,0,  1,0, 1,0),   // 12 R8 2->1
        mk(8, 0,0,0,  0,0,  1,0, 1,0),   // 13 R8 1->0
        mk(8, 0,0,0,  0,0,  0,0, 1,1),   // 14 R8 resumed
        mk(5, 0,0,0,  1,2,  0,0, 1,0),   // 15 R5 unarmed eviction
        mk(5, 0,0,0,  0,0,  0,0, 1,1),   // 16 R5 zero drain resumes
        mk(3, 1,3,0,  0,0,  0,0, 1,1),   // 17 R3 equal to cleared snapshot
        mk(3, 0,0,0,  1,3,  0,0, 1,0),   // 18 R3 so not armed
        mk(3, 0,0,0,  0,0,  0,0, 1,1),   // 19
        mk(7, 1,4,9,  0,0,  0,0, 1,1),   // 20 R7 arm set4
        mk(7, 0,0,0,  1,5,  0,0, 1,0),   // 21 R7 set5 saturates
        mk(7, 0,0,0,  1,4,  0,0, 1,0),   // 22 R7 set4 arm was cleared
        mk(7, 0,0,0,  0,0,  0,0, 1,1),   // 23
        mk(7, 1,6,12, 0,0,  0,0, 1,1),   // 24 R7 arm set6
        mk(7, 0,0,0,  1,6,  0,0, 1,1),   // 25 R7 set6 count 1
        mk(7, 0,0,0,  1,7,  0,0, 1,0),   // 26 R7 set7 saturates
        mk(7, 1,6,12, 0,0,  0,0, 1,1),   // 27 R7 snapshot was zeroed
        mk(7, 0,0,0,  1,6,  0,0, 1,1),   // 28 R7 armed -> count 1
        mk(7, 1,6,1,  0,0,  0,0, 1,1),   // 29
        mk(7, 0,0,0,  1,6,  0,0, 1,1),   // 30 R7 count 2 (old count gone)
        mk(4, 1,6,2,  0,0,  0,0, 1,1),   // 31
        mk(4, 0,0,0,  1,6,  0,0, 1,0),   // 32 R4 third saturates
        mk(4, 0,0,0,  0,0,  0,0, 1,1),   // 33
        mk(10,1,8,1,  0,0,  0,0, 1,1),   // 34 R10 arm set8
        mk(10,1,8,2,  1,8,  0,0, 1,1),   // 35 R10 evict + re-arm
        mk(10,0,0,0,  1,8,  0,0, 1,1),   // 36 R10 still armed
        mk(10,0,0,0,  1,8,  0,0, 1,0),   // 37 R10 now unarmed
        mk(10,0,0,0,  0,0,  0,0, 1,1),   // 38
        mk(11,1,9,1,  0,0,  0,0, 1,1),   // 39 R11 arm set9
        mk(11,1,10,1, 0,0,  0,0, 1,1),   // 40 R11 arm set10
        mk(11,0,0,0,  1,9,  0,0, 1,1),   // 41 R11
        mk(11,0,0,0,  1,10, 0,0, 1,1),   // 42 R11 separate arm
        mk(9, 0,0,0,  1,11, 0,3, 1,0),   // 43 R9 load 3
        mk(9, 0,0,0,  0,0,  1,0, 1,0),   // 44 R9 3->2
        mk(9, 0,0,0,  1,11, 1,5, 1,0),   // 45 R9 reload 5, retire ignored
        mk(9, 0,0,0,  0,0,  1,0, 1,0),   // 46 R9 5->4
        mk(9, 0,0,0,  0,0,  1,0, 1,0),   // 47 R9 4->3
        mk(9, 0,0,0,  0,0,  1,0, 1,0),   // 48 R9 3->2
        mk(9, 0,0,0,  0,0,  1,0, 1,0),   // 49 R9 2->1
        mk(9, 0,0,0,  0,0,  1,0, 1,0),   // 50 R9 1->0
        mk(9, 0,0,0,  0,0,  0,0, 1,1),   // 51 R9 resumed
        mk(8, 0,0,0,  0,0,  1,0, 1,1),   // 52 R8 retire at zero
        mk(8, 0,0,0,  0,0,  0,0, 1,1),   // 53 R8 no underflow
        mk(2, 0,0,0,  0,0,  0,0, 0,0)    // 54 R2
    };

    task automatic check(input int rq, input logic exp_v, input string what);
        checks++;
        if (snoop_filter !== exp_v) begin
            errors++;
            $display("FAIL R%0d %s: actual=%b expected=%b", rq, what, snoop_filter, exp_v);
        end
    endtask

    task automatic idle_inputs();
        acc_valid = 1'b0; evict_valid = 1'b0; retire = 1'b0;
        inflight_cnt = '0; snoop_valid = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // Table walk
        for (int i = 0; i < NROWS; i++) begin
            logic [29:0] v;
            @(negedge clk);
            v            = TBL[i];
            acc_valid    = v[25];
            acc_set      = v[24:21];
            acc_lru      = v[20:14];
            evict_valid  = v[13];
            evict_set    = v[12:9];
            retire       = v[8];
            inflight_cnt = v[7:2];
            snoop_valid  = v[1];
            #1;
            check(int'(v[29:26]), v[0], $sformatf("row %0d", i));
        end

        // Directed R1: reset in the middle of a drain restores filtering
        @(negedge clk);
        idle_inputs();
        evict_valid = 1'b1; evict_set = 4'd12; inflight_cnt = 6'd7; snoop_valid = 1'b1;
        #1 check(6, 1'b0, "saturation before reset");
        @(negedge clk);
        idle_inputs();
        snoop_valid = 1'b1;
        #1 check(8, 1'b0, "draining before reset");
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1 check(1, 1'b1, "reset clears drain");

        // Directed R5: first eviction after reset is unarmed
        @(negedge clk);
        evict_valid = 1'b1; evict_set = 4'd0;
        #1 check(5, 1'b0, "unarmed eviction after reset");
        @(negedge clk);
        idle_inputs();
        snoop_valid = 1'b1;
        #1 check(5, 1'b1, "zero drain after reset saturation");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule